// File: doc/BRIEF.md
# Bouncing Box Animation Controller

This block animates a solid 16x16 square that travels diagonally across a 128x128 pixel frame buffer. It does not own the pixel storage. It drives a single pixel-write port (write strobe, column, row, 24-bit colour) that an external frame buffer consumes. For every movement step it plots the square in its drawing colour at the current origin, holds it on screen until the next frame tick, and overwrites the same 256 pixels with black. It then advances both position counters by one pixel.

A free-running frame pacer fires once every `CLK_HZ / MOVES_PER_SEC` clock cycles, so the square moves four times per second at the default settings. Two direction bits, one per axis, choose whether each coordinate counts up or down. An axis reverses when its next position would leave the legal origin range 0..112, so the square bounces off all four edges and never wraps.

The sequencer has five states. IDLE is the reset state. DRAW plots the square in colour. HOLD keeps it displayed. ERASE plots black over it. MOVE updates the direction bits and the counters. The transitions are: *launch* (IDLE to DRAW, one cycle after reset), *draw_done* (DRAW to HOLD after the 256th pixel), *frame_tick* (HOLD to ERASE when the pacer fires), *erase_done* (ERASE to MOVE after the 256th pixel) and *moved* (MOVE to DRAW, always after one cycle).

Top module: `bounce_box_ctrl`

## Requirements
- R1: While reset is active, the block issues no pixel write. The first cycle after reset is released issues none either. The first draw burst begins in the second cycle after release, at origin (0,0).
- R2: A draw burst lasts 256 consecutive cycles with the write strobe high and colour `DRAW_COLOR`. Pixel i (0..255) is written at column origin_x + (i mod 16) and row origin_y + (i div 16), so pixels are written row by row with the lowest column first.
- R3: An erase burst writes the same 256 pixels in the same order as the preceding draw burst, with colour 0 (black).
- R4: Consecutive erase bursts start exactly `CLK_HZ / MOVES_PER_SEC` cycles apart. The erase burst begins in the cycle after the frame tick.
- R5: After each erase burst there is exactly one cycle with no write. The next draw burst then begins at an origin that differs by exactly one pixel on each axis. After reset, both axes first move in the increasing direction (down and to the right).
- R6: An axis whose origin is 112 while moving in the increasing direction reverses, and its next origin is 111.
- R7: An axis whose origin is 0 while moving in the decreasing direction reverses, and its next origin is 1.
- R8: Every origin stays within 0..112 on both axes, so no pixel of the square wraps across a screen edge.
- R9: Between the end of a draw burst and the start of its erase burst, no pixel write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_we | output | 1 | Pixel write strobe to the frame buffer |
| pix_x | output | 7 | Column of the pixel being written (0 = left) |
| pix_y | output | 7 | Row of the pixel being written (0 = top) |
| pix_rgb | output | 24 | Pixel colour, red in the top byte and blue in the bottom byte |

## Verification
The bench builds the block with `CLK_HZ` = 2400, which gives a 600-cycle frame period. More than 228 steps then fit in the run, enough for the square to reach the bottom-right limit at 112, bounce, come back to the top-left corner and bounce again. The drawing colour is set to a value with distinct bytes, so draw and erase bursts cannot be confused. Reset is also applied at random points in the middle of bursts and holds, and the bench checks that the animation restarts cleanly from the corner each time.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAW,
        ST_HOLD,
        ST_ERASE,
        ST_MOVE
    } bb_state_t;

    function automatic int frame_reload(input int clk_hz, input int per_sec);
        return (clk_hz / per_sec) - 1;
    endfunction

endpackage

// File: rtl/bb_pacer.sv
module bb_pacer #(
    parameter int RELOAD = 1199
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (RELOAD < 2) ? 1 : $clog2(RELOAD + 1);

    logic [CW-1:0] count;

    assign tick = (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CW'(RELOAD);
        end else if (tick) begin
            count <= CW'(RELOAD);
        end else begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/bb_scan.sv
module bb_scan #(
    parameter int BOX = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      active,
    output logic [$clog2(BOX)-1:0]    col,
    output logic [$clog2(BOX)-1:0]    row,
    output logic                      last
);
    localparam int SW = $clog2(BOX);
    localparam int NW = 2 * SW;

    logic [NW-1:0] idx;

    assign col  = idx[SW-1:0];
    assign row  = idx[NW-1:SW];
    assign last = active && (idx == {NW{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n || !active || last) begin
            idx <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/bb_axis.sv
module bb_axis #(
    parameter int CW      = 7,
    parameter int MAX_ORG = 112
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] org,
    output logic          fwd
);
    logic at_hi;
    logic at_lo;
    logic fwd_next;

    assign at_hi    = (org == CW'(MAX_ORG));
    assign at_lo    = (org == '0);
    assign fwd_next = fwd ? !at_hi : at_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            org <= '0;
            fwd <= 1'b1;
        end else if (step) begin
            fwd <= fwd_next;
            org <= fwd_next ? org + 1'b1 : org - 1'b1;
        end
    end
endmodule

// File: rtl/bb_fsm.sv
module bb_fsm
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scan_last,
    input  logic      frame_tick,
    output bb_state_t state,
    output logic      scan_on,
    output logic      plot_color,
    output logic      do_step
);
    bb_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_DRAW;
            ST_DRAW:  if (scan_last)  state_nx = ST_HOLD;
            ST_HOLD:  if (frame_tick) state_nx = ST_ERASE;
            ST_ERASE: if (scan_last)  state_nx = ST_MOVE;
            ST_MOVE:  state_nx = ST_DRAW;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        scan_on    = 1'b0;
        plot_color = 1'b0;
        do_step    = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_DRAW:  begin scan_on = 1'b1; plot_color = 1'b1; end
            ST_HOLD:  ;
            ST_ERASE: scan_on = 1'b1;
            ST_MOVE:  do_step = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bounce_box_ctrl.sv
module bounce_box_ctrl
    import bb_pkg::*;
#(
    parameter int          CLK_HZ        = 50_000_000,
    parameter int          MOVES_PER_SEC = 4,
    parameter int          SCREEN        = 128,
    parameter int          BOX           = 16,
    parameter int          COLOR_W       = 24,
    parameter logic [23:0] DRAW_COLOR    = 24'hFF_00_FF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      pix_we,
    output logic [$clog2(SCREEN)-1:0] pix_x,
    output logic [$clog2(SCREEN)-1:0] pix_y,
    output logic [COLOR_W-1:0]        pix_rgb
);
    localparam int CW      = $clog2(SCREEN);
    localparam int SW      = $clog2(BOX);
    localparam int MAX_ORG = SCREEN - BOX;
    localparam int RELOAD  = frame_reload(CLK_HZ, MOVES_PER_SEC);

    bb_state_t      state;
    logic           frame_tick;
    logic           scan_on;
    logic           scan_last;
    logic           plot_color;
    logic           do_step;
    logic [SW-1:0]  col;
    logic [SW-1:0]  row;
    logic [CW-1:0]  org [2];
    logic           fwd [2];
    logic [CW-1:0]  box_x;
    logic [CW-1:0]  box_y;
    logic           dir_x;
    logic           dir_y;

    bb_pacer #(.RELOAD(RELOAD)) u_pacer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (frame_tick)
    );

    bb_scan #(.BOX(BOX)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .active(scan_on),
        .col   (col),
        .row   (row),
        .last  (scan_last)
    );

    bb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_last (scan_last),
        .frame_tick(frame_tick),
        .state     (state),
        .scan_on   (scan_on),
        .plot_color(plot_color),
        .do_step   (do_step)
    );

    for (genvar a = 0; a < 2; a++) begin : g_axis
        bb_axis #(.CW(CW), .MAX_ORG(MAX_ORG)) u_axis (
            .clk  (clk),
            .rst_n(rst_n),
            .step (do_step),
            .org  (org[a]),
            .fwd  (fwd[a])
        );
    end

    assign box_x = org[0];
    assign box_y = org[1];
    assign dir_x = fwd[0];
    assign dir_y = fwd[1];

    assign pix_we  = scan_on;
    assign pix_x   = box_x + CW'(col);
    assign pix_y   = box_y + CW'(row);
    assign pix_rgb = plot_color ? COLOR_W'(DRAW_COLOR) : '0;
endmodule

// File: rtl/bb_chk.sv
module bb_chk
    import bb_pkg::*;
#(
    parameter int          CW         = 7,
    parameter int          MAX_ORG    = 112,
    parameter int          RELOAD     = 1199,
    parameter int          COLOR_W    = 24,
    parameter logic [23:0] DRAW_COLOR = 24'hFF_00_FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bb_state_t          state,
    input  logic               frame_tick,
    input  logic               do_step,
    input  logic [CW-1:0]      box_x,
    input  logic [CW-1:0]      box_y,
    input  logic               dir_x,
    input  logic               dir_y,
    input  logic               pix_we,
    input  logic [COLOR_W-1:0] pix_rgb
);
    logic [31:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_tick) gap <= '0;
        else                      gap <= gap + 1'b1;
    end

    // R4
    tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> gap == 32'(RELOAD));

    // R9
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !frame_tick) |=> (state == ST_HOLD && !pix_we));

    // R2
    draw_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_we && state == ST_DRAW) |-> pix_rgb == COLOR_W'(DRAW_COLOR));

    // R3
    erase_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_we && state == ST_ERASE) |-> pix_rgb == '0);

    // R5
    step_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_step |=> (box_x == $past(box_x) + 1'b1 || box_x == $past(box_x) - 1'b1));

    // R5
    step_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_step |=> (box_y == $past(box_y) + 1'b1 || box_y == $past(box_y) - 1'b1));

    // R5
    idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_step |=> ($stable(box_x) && $stable(box_y)));

    // R6
    bounce_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && dir_x && box_x == CW'(MAX_ORG)) |=> !dir_x);

    // R7
    bounce_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && !dir_y && box_y == '0) |=> dir_y);

    // R8
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (box_x <= CW'(MAX_ORG) && box_y <= CW'(MAX_ORG)));
endmodule

bind bounce_box_ctrl bb_chk #(
    .CW        (CW),
    .MAX_ORG   (MAX_ORG),
    .RELOAD    (RELOAD),
    .COLOR_W   (COLOR_W),
    .DRAW_COLOR(DRAW_COLOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .frame_tick(frame_tick),
    .do_step   (do_step),
    .box_x     (box_x),
    .box_y     (box_y),
    .dir_x     (dir_x),
    .dir_y     (dir_y),
    .pix_we    (pix_we),
    .pix_rgb   (pix_rgb)
);

// File: tb/sim_bounce_box_ctrl.sv
module sim_bounce_box_ctrl;
    localparam int          CLK_HZ = 2400;
    localparam int          PERIOD = 600;
    localparam int          MAXO   = 112;
    localparam int          NPIX   = 256;
    localparam logic [23:0] COL    = 24'h3C_A0_F5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_we;
    logic [6:0]  pix_x;
    logic [6:0]  pix_y;
    logic [23:0] pix_rgb;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bounce_box_ctrl #(.CLK_HZ(CLK_HZ), .DRAW_COLOR(COL)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_we (pix_we),
        .pix_x  (pix_x),
        .pix_y  (pix_y),
        .pix_rgb(pix_rgb)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_org(input int k);
        int p = k % (2 * MAXO);
        return (p <= MAXO) ? p : 2 * MAXO - p;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Waits for the next write burst and follows it to its end.
    task automatic burst(output int ox, output int oy, output int color,
                         output int start, output int errs);
        errs = 0;
        while (!pix_we) @(negedge clk);
        start = cyc;
        ox = pix_x;
        oy = pix_y;
        color = pix_rgb;
        for (int i = 0; i < NPIX; i++) begin
            if (!pix_we || pix_rgb != 24'(color) ||
                pix_x != 7'((ox + i % 16) & 127) ||
                pix_y != 7'((oy + i / 16) & 127)) errs++;
            @(negedge clk);
        end
        if (pix_we) errs++;
    endtask

    task automatic run_steps(input int n, input int rel);
        int dx, dy, dc, ds, de, ex, ey, ec, es, ee;
        int prev_es, prev_last;
        prev_es = 0;
        prev_last = 0;
        for (int k = 0; k < n; k++) begin
            burst(dx, dy, dc, ds, de);
            if (k == 0) begin
                chk(ds - rel == 1, "R1", "first draw delay", ds - rel, 1);
                chk(dx == 0 && dy == 0, "R1", "start origin", dx * 1000 + dy, 0);
            end else begin
                chk(ds - prev_last == 2, "R5", "erase-to-draw spacing", ds - prev_last, 2);
            end
            chk(dx == exp_org(k), "R5", "origin x", dx, exp_org(k));
            chk(dy == exp_org(k), "R5", "origin y", dy, exp_org(k));
            chk(dx <= MAXO && dy <= MAXO, "R8", "origin range", dx > dy ? dx : dy, MAXO);
            if (k % (2 * MAXO) == MAXO + 1)
                chk(dx == MAXO - 1 && dy == MAXO - 1, "R6", "bounce at high edge", dx, MAXO - 1);
            if (k > 0 && k % (2 * MAXO) == 1)
                chk(dx == 1 && dy == 1, "R7", "bounce at low edge", dx, 1);
            chk(dc == int'(COL), "R2", "draw colour", dc, int'(COL));
            chk(de == 0, "R2", "draw scan errors", de, 0);
            burst(ex, ey, ec, es, ee);
            chk(ex == dx && ey == dy, "R3", "erase origin", ex * 1000 + ey, dx * 1000 + dy);
            chk(ec == 0, "R3", "erase colour", ec, 0);
            chk(ee == 0, "R3", "erase scan errors", ee, 0);
            chk(es - ds >= NPIX, "R9", "hold before erase", es - ds, NPIX);
            if (k > 0)
                chk(es - prev_es == PERIOD, "R4", "frame period", es - prev_es, PERIOD);
            prev_es = es;
            prev_last = es + NPIX - 1;
        end
    endtask

    task automatic do_reset(input int len);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            chk(!pix_we, "R1", "write during reset", pix_we, 0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2718));
        do_reset(4);
        run_steps(228, cyc);
        for (int r = 0; r < 3; r++) begin
            repeat ($urandom % 1500) @(negedge clk);
            do_reset(1 + $urandom % 5);
            run_steps(3 + $urandom % 4, cyc);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end
endmodule